// File: doc/BRIEF.md
# Segment Selection and Linear Address Generator

This block picks one of six segment registers for each memory reference and forms the linear address as that segment's base plus the supplied 32-bit offset. The choice depends on the kind of reference and on the base register used by the effective address. Some reference kinds are tied to one segment whatever override prefix accompanies them. For ordinary data references an override code can redirect the access to any of the six segments.

The block keeps a base and a limit for every segment, loaded through a simple write port. Each request is checked against the limit of the chosen segment. The result appears one clock after the request strobe and carries the segment index, the linear address, and either a valid strobe or a fault flag.

Top module: `segsel_agen`

## Requirements
- R1: A request with `ref_kind`=0 (instruction fetch) selects segment index 1 (code), whatever the `ovr` value.
- R2: A request with `ref_kind`=1 (stack push/pop, including push-all and pop-all) selects segment index 2 (stack), whatever the `ovr` value.
- R3: A request with `ref_kind`=2 (data) and no override selects index 3 (data) when `base_reg` is 0,1,2,3,6 or 7 (EAX, ECX, EDX, EBX, ESI, EDI).
- R4: A request with `ref_kind`=2 and no override selects index 2 (stack) when `base_reg` is 4 or 5 (ESP, EBP).
- R5: For `ref_kind`=2, an `ovr` value from 0 to 5 selects that segment (0 extra, 1 code, 2 stack, 3 data, 4 F, 5 G). Values 6 and 7 mean no override.
- R6: A request with `ref_kind`=3 (string store/move destination) selects index 0 (extra), whatever the `ovr` value.
- R7: One clock after `req`, `out_lin` equals segment base plus offset modulo 2^32, and `out_seg` equals the chosen index. With every base at zero, `out_lin` equals the offset.
- R8: When offset + `acc_last` exceeds the chosen segment's limit (computed without wraparound), `out_fault` pulses one clock after `req` and `out_valid` stays low. Otherwise `out_valid` pulses and `out_fault` stays low. `acc_last` is the access size in bytes minus one, and the limit is the last valid byte offset.
- R9: When a segment write and a request that selects the same segment fall in the same cycle, the address and the limit check use the newly written base and limit.
- R10: After reset every base is 0, every limit is 0xFFFFFFFF, and `out_valid` and `out_fault` are low. Writes with `wr_idx` above 5 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request strobe |
| ref_kind | input | 2 | 0 fetch, 1 stack, 2 data, 3 string destination |
| base_reg | input | 3 | Base register of the effective address |
| ovr | input | 3 | Override segment code, 6/7 = none |
| acc_last | input | 2 | Access size in bytes minus one |
| offset | input | 32 | Effective address offset |
| wr_en | input | 1 | Segment write enable |
| wr_idx | input | 3 | Segment written |
| wr_base | input | 32 | New base |
| wr_limit | input | 32 | New limit (last valid offset) |
| out_valid | output | 1 | Address valid, one clock after req |
| out_fault | output | 1 | Limit fault, one clock after req |
| out_seg | output | 3 | Chosen segment index |
| out_lin | output | 32 | Linear address |

## Verification
The hardest case to reach from the ports is a write to a segment in the same cycle as a request that selects it. Register-file forwarding only shows up there. The bench drives both in one cycle, first with a new base and then with a shrunk limit, so that a stale read would give a wrong address or a missing fault. The limit boundary at the carry out of bit 31 also needs care. An offset of 0xFFFFFFFF with a multi-byte access has to fault even under the full limit, and the bench drives exactly that.

// File: rtl/segsel_pkg.sv
package segsel_pkg;
  typedef logic [2:0] seg_t;
  localparam seg_t SEG_ES = 3'd0;
  localparam seg_t SEG_CS = 3'd1;
  localparam seg_t SEG_SS = 3'd2;
  localparam seg_t SEG_DS = 3'd3;
  localparam seg_t SEG_FS = 3'd4;
  localparam seg_t SEG_GS = 3'd5;
  localparam int   NSEG   = 6;

  typedef enum logic [1:0] {
    K_FETCH  = 2'd0,
    K_STACK  = 2'd1,
    K_DATA   = 2'd2,
    K_STRDST = 2'd3
  } ref_kind_t;

  localparam logic [2:0] BR_ESP = 3'd4;
  localparam logic [2:0] BR_EBP = 3'd5;
endpackage

// File: rtl/segsel_pick.sv
module segsel_pick
  import segsel_pkg::*;
(
  input  logic [1:0] ref_kind,
  input  logic [2:0] base_reg,
  input  logic [2:0] ovr,
  output seg_t       seg
);
  logic ovr_present;
  seg_t data_default;

  always_comb begin
    ovr_present  = (ovr < 3'(NSEG));
    data_default = ((base_reg == BR_ESP) || (base_reg == BR_EBP)) ? SEG_SS : SEG_DS;
    unique case (ref_kind_t'(ref_kind))
      K_FETCH:  seg = SEG_CS;
      K_STACK:  seg = SEG_SS;
      K_STRDST: seg = SEG_ES;
      default:  seg = ovr_present ? seg_t'(ovr) : data_default;
    endcase
  end

  always_comb begin
    assert_pick_range_R5: assert (seg < 3'(NSEG));
  end
endmodule

// File: rtl/segsel_regfile.sv
module segsel_regfile
  import segsel_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_idx,
  input  logic [AW-1:0] wr_base,
  input  logic [AW-1:0] wr_limit,
  input  seg_t          rd_idx,
  output logic [AW-1:0] rd_base,
  output logic [AW-1:0] rd_limit
);
  logic [AW-1:0] base_q [NSEG];
  logic [AW-1:0] lim_q  [NSEG];

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    logic          we;
    logic [AW-1:0] base_d, lim_d;
    always_comb begin
      we     = wr_en && (wr_idx == 3'(g));
      base_d = we ? wr_base  : base_q[g];
      lim_d  = we ? wr_limit : lim_q[g];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[g] <= '0;
        lim_q[g]  <= '1;
      end else if (we) begin
        base_q[g] <= base_d;
        lim_q[g]  <= lim_d;
      end
    end
  end

  // forward a same-cycle write to the reader (R9)
  always_comb begin
    if (wr_en && (wr_idx == rd_idx)) begin
      rd_base  = wr_base;
      rd_limit = wr_limit;
    end else begin
      rd_base  = base_q[rd_idx];
      rd_limit = lim_q[rd_idx];
    end
  end
endmodule

// File: rtl/segsel_agen.sv
module segsel_agen
  import segsel_pkg::*;
#(
  parameter int AW = 32,
  parameter int SZW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req,
  input  logic [1:0]     ref_kind,
  input  logic [2:0]     base_reg,
  input  logic [2:0]     ovr,
  input  logic [SZW-1:0] acc_last,
  input  logic [AW-1:0]  offset,
  input  logic           wr_en,
  input  logic [2:0]     wr_idx,
  input  logic [AW-1:0]  wr_base,
  input  logic [AW-1:0]  wr_limit,
  output logic           out_valid,
  output logic           out_fault,
  output logic [2:0]     out_seg,
  output logic [AW-1:0]  out_lin
);
  localparam int EW = AW + 1;

  logic       rst_m, rst_s;
  seg_t       seg_c;
  logic [AW-1:0] base_c, lim_c, lin_c;
  logic [EW-1:0] end_c;
  logic       fault_c;
  logic       valid_d, fault_d;
  seg_t       seg_d, seg_q;
  logic [AW-1:0] lin_d, lin_q;
  logic       valid_q, fault_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  segsel_pick u_pick (
    .ref_kind (ref_kind),
    .base_reg (base_reg),
    .ovr      (ovr),
    .seg      (seg_c)
  );

  segsel_regfile #(.AW(AW)) u_rf (
    .clk      (clk),
    .rst_n    (rst_s),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_base  (wr_base),
    .wr_limit (wr_limit),
    .rd_idx   (seg_c),
    .rd_base  (base_c),
    .rd_limit (lim_c)
  );

  always_comb begin
    lin_c   = base_c + offset;
    end_c   = {1'b0, offset} + EW'(acc_last);
    fault_c = end_c > {1'b0, lim_c};
    valid_d = req && !fault_c;
    fault_d = req && fault_c;
    seg_d   = req ? seg_c : seg_q;
    lin_d   = req ? lin_c : lin_q;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      valid_q <= 1'b0;
      fault_q <= 1'b0;
      seg_q   <= SEG_ES;
      lin_q   <= '0;
    end else begin
      valid_q <= valid_d;
      fault_q <= fault_d;
      if (req) begin
        seg_q <= seg_d;
        lin_q <= lin_d;
      end
    end
  end

  assign out_valid = valid_q;
  assign out_fault = fault_q;
  assign out_seg   = seg_q;
  assign out_lin   = lin_q;

  assert_fetch_cs_R1: assert property (@(posedge clk) disable iff (!rst_s)
    (req && ref_kind == 2'd0) |=> (out_seg == SEG_CS));
  assert_stack_ss_R2: assert property (@(posedge clk) disable iff (!rst_s)
    (req && ref_kind == 2'd1) |=> (out_seg == SEG_SS));
  assert_strdst_es_R6: assert property (@(posedge clk) disable iff (!rst_s)
    (req && ref_kind == 2'd3) |=> (out_seg == SEG_ES));
  assert_excl_R8: assert property (@(posedge clk) disable iff (!rst_s)
    !(out_valid && out_fault));
  assert_resp_needs_req_R7: assert property (@(posedge clk) disable iff (!rst_s)
    (out_valid || out_fault) |-> $past(req));
  assert_resp_follows_req_R8: assert property (@(posedge clk) disable iff (!rst_s)
    req |=> $countones({out_valid, out_fault}) == 1);
endmodule

// File: tb/segsel_agen_tb.sv
module segsel_agen_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req;
  logic [1:0]  ref_kind;
  logic [2:0]  base_reg, ovr;
  logic [1:0]  acc_last;
  logic [31:0] offset;
  logic        wr_en;
  logic [2:0]  wr_idx;
  logic [31:0] wr_base, wr_limit;
  logic        out_valid, out_fault;
  logic [2:0]  out_seg;
  logic [31:0] out_lin;

  int total = 0;
  int bad = 0;
  logic [31:0] mb [6];
  logic [31:0] ml [6];

  always #10 clk = ~clk;

  segsel_agen u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .ref_kind(ref_kind),
    .base_reg(base_reg), .ovr(ovr), .acc_last(acc_last), .offset(offset),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_base(wr_base), .wr_limit(wr_limit),
    .out_valid(out_valid), .out_fault(out_fault), .out_seg(out_seg), .out_lin(out_lin)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] model_seg(logic [1:0] k, logic [2:0] br, logic [2:0] ov);
    if (k == 2'd0) return 3'd1;
    if (k == 2'd1) return 3'd2;
    if (k == 2'd3) return 3'd0;
    if (ov < 3'd6) return ov;
    return (br == 3'd4 || br == 3'd5) ? 3'd2 : 3'd3;
  endfunction

  task automatic wr(logic [2:0] idx, logic [31:0] b, logic [31:0] l);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_base = b; wr_limit = l;
    @(negedge clk);
    wr_en = 1'b0;
    if (idx < 3'd6) begin mb[idx] = b; ml[idx] = l; end
  endtask

  // issue one request (optionally with a same-cycle write) and check all outputs
  task automatic issue(string tag, logic [1:0] k, logic [2:0] br, logic [2:0] ov,
                       logic [1:0] last, logic [31:0] off,
                       logic w = 1'b0, logic [2:0] wi = 3'd0,
                       logic [31:0] wb = 0, logic [31:0] wl = 0);
    logic [2:0]  es;
    logic        ef;
    @(negedge clk);
    req = 1'b1; ref_kind = k; base_reg = br; ovr = ov; acc_last = last; offset = off;
    wr_en = w; wr_idx = wi; wr_base = wb; wr_limit = wl;
    if (w && wi < 3'd6) begin mb[wi] = wb; ml[wi] = wl; end
    es = model_seg(k, br, ov);
    ef = ({1'b0, off} + 33'(last)) > {1'b0, ml[es]};
    @(negedge clk);
    req = 1'b0; wr_en = 1'b0;
    check({tag, " seg"},   32'(out_seg), 32'(es));
    check({tag, " fault"}, 32'(out_fault), 32'(ef));
    check({tag, " valid"}, 32'(out_valid), 32'(!ef));
    if (!ef) check({tag, " lin"}, out_lin, mb[es] + off);
  endtask

  task automatic t_reset;
    check("R10 reset valid", 32'(out_valid), 0);
    check("R10 reset fault", 32'(out_fault), 0);
    issue("R10 flat top R7", 2'd2, 3'd0, 3'd7, 2'd0, 32'hFFFF_FFFF);
    issue("R10 flat mid", 2'd2, 3'd3, 3'd7, 2'd3, 32'h1234_5678);
  endtask

  task automatic t_forced;
    for (int o = 0; o < 8; o++) begin
      issue("R1 fetch", 2'd0, 3'd3, 3'(o), 2'd0, 32'h100);
      issue("R2 stack", 2'd1, 3'd4, 3'(o), 2'd3, 32'h200);
      issue("R6 strdst", 2'd3, 3'd7, 3'(o), 2'd1, 32'h300);
    end
  endtask

  task automatic t_data;
    for (int b = 0; b < 8; b++) begin
      if (b == 4 || b == 5) issue("R4 data ss", 2'd2, 3'(b), 3'd6, 2'd0, 32'h40);
      else                  issue("R3 data ds", 2'd2, 3'(b), 3'd7, 2'd0, 32'h40);
      for (int o = 0; o < 6; o++)
        issue("R5 override", 2'd2, 3'(b), 3'(o), 2'd0, 32'h44);
    end
  endtask

  task automatic t_wrap;
    issue("R7 wrap", 2'd2, 3'd0, 3'd7, 2'd0, 32'hFFFF_F000);
    issue("R7 ebp base", 2'd2, 3'd5, 3'd7, 2'd1, 32'h0000_0010);
  endtask

  task automatic t_limit;
    issue("R8 in bound", 2'd2, 3'd0, 3'd4, 2'd3, 32'h0000_000C);
    issue("R8 over by one", 2'd2, 3'd0, 3'd4, 2'd3, 32'h0000_000D);
    issue("R8 one byte seg ok", 2'd2, 3'd0, 3'd5, 2'd0, 32'h0);
    issue("R8 one byte seg over", 2'd2, 3'd0, 3'd5, 2'd0, 32'h1);
    issue("R8 carry out", 2'd2, 3'd0, 3'd3, 2'd1, 32'hFFFF_FFFF);
  endtask

  task automatic t_bypass;
    issue("R9 new base", 2'd2, 3'd0, 3'd5, 2'd0, 32'h10, 1'b1, 3'd5, 32'h7000, 32'hFF);
    issue("R9 new limit", 2'd2, 3'd1, 3'd7, 2'd0, 32'h80, 1'b1, 3'd3, 32'h9000, 32'h7F);
    issue("R9 other seg", 2'd1, 3'd4, 3'd7, 2'd0, 32'h20, 1'b1, 3'd4, 32'hAAAA, 32'h0);
  endtask

  task automatic t_bad_idx;
    wr(3'd6, 32'hDEAD_0000, 32'h0);
    wr(3'd7, 32'hBEEF_0000, 32'h0);
    for (int o = 0; o < 6; o++)
      issue("R10 idx>5 ignored", 2'd2, 3'd0, 3'(o), 2'd0, 32'h4);
  endtask

  initial begin
    req = 0; ref_kind = 0; base_reg = 0; ovr = 7; acc_last = 0; offset = 0;
    wr_en = 0; wr_idx = 0; wr_base = 0; wr_limit = 0;
    for (int i = 0; i < 6; i++) begin mb[i] = 0; ml[i] = 32'hFFFF_FFFF; end
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    for (int i = 0; i < 6; i++) wr(3'(i), 32'h1000 * (i + 1), 32'hFFFF_FFFF);
    t_forced();
    t_data();
    t_wrap();
    wr(3'd4, 32'h5000, 32'h0000_000F);
    wr(3'd5, 32'h6000, 32'h0);
    t_limit();
    t_bypass();
    t_bad_idx();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule